// File: doc/BRIEF.md
# Dual-Form Serial CRC Engine

This block computes a cyclic redundancy check one message bit per clock. The remainder is the message polynomial multiplied by x^W and reduced modulo a generator polynomial of degree W. The generator is a parameter. Its default is x^5 + x^2 + x + 1, which gives a five-bit remainder. The caller pulses a start control, then presents the message most significant bit first. Each bit is qualified by a valid strobe, and the final bit also carries an end-of-message flag. A one-cycle done pulse marks the moment the remainder output is final.

A mode input, sampled at start, selects how the division is carried out. In the direct form each incoming bit is folded into the feedback term, so the result is ready right after the last message bit. In the augmented form the raw bits enter the low end of the register, and only the bit leaving the top drives the feedback. After the last message bit the block shifts in W zero bits on its own, so this form takes W more cycles. Both forms must arrive at the same remainder.

Top module: `crc_dual_serial`

## Requirements
- R1: With the default generator x^5 + x^2 + x + 1 and the 8-bit message 10010011 sent MSB first, both forms finish with remainder 01010 on `crc_o`.
- R2: `start_i` high at a clock edge sets the register to zero and drops `done_o` at that edge. It also latches `mode_i`: 0 selects the direct form and 1 the augmented form. A data bit presented in the same cycle is discarded.
- R3: In direct form each accepted bit D updates state {c4..c0} to {c3, c2, c1^c4^D, c0^c4^D, c4^D}, generalised to W bits with the generator's low coefficients.
- R4: In augmented form an accepted bit is shifted into bit 0 unmodified, and the bit leaving the top selects the feedback. After the bit flagged last, exactly W zero bits are shifted in internally.
- R5: For any message of 1 to 16 bits, sent MSB first with arbitrary idle cycles (`valid_i` low) between bits, both forms yield the remainder of M(x)·x^W mod G(x).
- R6: In direct form `done_o` is high in the cycle right after the clock edge that accepts the last bit. An 8-bit message therefore takes 8 shifts.
- R7: In augmented form `done_o` is high W+1 cycles after the edge that accepts the last bit. An 8-bit message therefore takes 8+5 = 13 shifts.
- R8: `done_o` is high for exactly one cycle per completed message.
- R9: Once the result is final, `crc_o` holds its value until the next start, whatever `valid_i`, `bit_i` and `last_i` do.
- R10: Input presented while zero padding is under way has no effect on the result.
- R11: A start while a message is in progress abandons it. The following message computes as if nothing came before.
- R12: After reset `crc_o` is zero and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new message, clearing the register |
| mode_i | input | 1 | Form selected at start: 0 direct, 1 augmented |
| valid_i | input | 1 | `bit_i` carries a message bit this cycle |
| bit_i | input | 1 | Message bit, MSB first |
| last_i | input | 1 | Qualified bit is the final message bit |
| crc_o | output | W | Remainder register |
| done_o | output | 1 | One-cycle pulse: remainder is final |

## Verification
The bench measures the gap from the last accepted bit to `done_o` in each form. A design that pads the wrong number of zeros, or pads in direct mode, is caught both by this count and by a wrong remainder. One-bit messages and messages with idle gaps catch designs that shift on invalid cycles or mishandle the first bit. Stimulus is left asserted during padding and after completion, which exposes a design that lets input leak into the padding or into the held result. A start issued in mid-message checks that stale register contents and a stale mode do not survive the restart.

// File: rtl/crc_dual_pkg.sv
package crc_dual_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_PAD   = 2'd2
   } crc_state_e;

   typedef enum logic {
      FORM_DIRECT  = 1'b0,
      FORM_AUGMENT = 1'b1
   } crc_form_e;
endpackage

// File: rtl/crc_step.sv
// One shift of the division register in the form chosen by AUGMENT.
module crc_step #(
   parameter int          W       = 5,
   parameter logic [W-1:0] POLY   = 5'b00111,
   parameter bit          AUGMENT = 1'b0
) (
   input  logic [W-1:0] cur_i,
   input  logic         din_i,
   output logic [W-1:0] nxt_o
);
   generate
      if (AUGMENT) begin : g_aug
         // raw bit enters at the bottom; outgoing top bit drives feedback
         always_comb nxt_o = {cur_i[W-2:0], din_i} ^ ({W{cur_i[W-1]}} & POLY);
      end else begin : g_dir
         // incoming bit folded into the feedback term
         logic fb;
         always_comb begin
            fb    = cur_i[W-1] ^ din_i;
            nxt_o = {cur_i[W-2:0], 1'b0} ^ ({W{fb}} & POLY);
         end
      end
   endgenerate
endmodule

// File: rtl/crc_seq_ctrl.sv
// Sequencing: message phase, internal zero padding, done pulse.
module crc_seq_ctrl
   import crc_dual_pkg::*;
#(
   parameter int W  = 5,
   localparam int CW = (W > 2) ? $clog2(W) : 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic        mode_i,
   input  logic        valid_i,
   input  logic        bit_i,
   input  logic        last_i,
   output logic        clr_o,
   output logic        shift_o,
   output logic        din_o,
   output crc_form_e   form_o,
   output crc_state_e  state_o,
   output logic [CW-1:0] pad_cnt_o,
   output logic        done_o
);
   localparam logic [CW-1:0] PAD_LAST = CW'(W - 1);

   crc_state_e      state_q;
   crc_form_e       form_q;
   logic [CW-1:0]   cnt_q;
   logic            done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         form_q  <= FORM_DIRECT;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_i) begin
            state_q <= ST_SHIFT;
            form_q  <= crc_form_e'(mode_i);
            cnt_q   <= '0;
         end else begin
            unique case (state_q)
               ST_SHIFT: begin
                  if (valid_i && last_i) begin
                     if (form_q == FORM_AUGMENT) begin
                        state_q <= ST_PAD;
                        cnt_q   <= '0;
                     end else begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                     end
                  end
               end
               ST_PAD: begin
                  if (cnt_q == PAD_LAST) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      clr_o     = start_i;
      shift_o   = !start_i && ((state_q == ST_SHIFT && valid_i) || state_q == ST_PAD);
      din_o     = (state_q == ST_SHIFT) ? bit_i : 1'b0;
      form_o    = form_q;
      state_o   = state_q;
      pad_cnt_o = cnt_q;
      done_o    = done_q;
   end
endmodule

// File: rtl/crc_dual_serial.sv
module crc_dual_serial
   import crc_dual_pkg::*;
#(
   parameter int           W    = 5,
   parameter logic [W-1:0] POLY = 5'b00111,
   localparam int          CW   = (W > 2) ? $clog2(W) : 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic         mode_i,
   input  logic         valid_i,
   input  logic         bit_i,
   input  logic         last_i,
   output logic [W-1:0] crc_o,
   output logic         done_o
);
   generate
      if (W < 2) begin : g_bad_width
         $error("crc_dual_serial: W must be at least 2");
      end
      if (POLY[0] != 1'b1) begin : g_bad_poly
         $error("crc_dual_serial: generator needs a constant term");
      end
   endgenerate

   logic          clr, shift, din;
   crc_form_e     form;
   crc_state_e    ctl_state;
   logic [CW-1:0] pad_cnt;
   logic [W-1:0]  rem_q;
   logic [W-1:0]  nxt_form [2];

   crc_seq_ctrl #(.W(W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .mode_i    (mode_i),
      .valid_i   (valid_i),
      .bit_i     (bit_i),
      .last_i    (last_i),
      .clr_o     (clr),
      .shift_o   (shift),
      .din_o     (din),
      .form_o    (form),
      .state_o   (ctl_state),
      .pad_cnt_o (pad_cnt),
      .done_o    (done_o)
   );

   generate
      for (genvar f = 0; f < 2; f++) begin : g_form
         crc_step #(.W(W), .POLY(POLY), .AUGMENT(f == 1)) u_step (
            .cur_i (rem_q),
            .din_i (din),
            .nxt_o (nxt_form[f])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rem_q <= '0;
      else if (clr)    rem_q <= '0;
      else if (shift)  rem_q <= nxt_form[form];
   end

   assign crc_o = rem_q;
endmodule

// File: rtl/crc_dual_serial_chk.sv
module crc_dual_serial_chk
   import crc_dual_pkg::*;
#(
   parameter int W  = 5,
   localparam int CW = (W > 2) ? $clog2(W) : 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          valid_i,
   input logic          last_i,
   input logic [W-1:0]  crc_o,
   input logic          done_o,
   input crc_state_e    st,
   input crc_form_e     form,
   input logic [CW-1:0] pad_cnt
);
   localparam logic [CW-1:0] PAD_LAST = CW'(W - 1);

   assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (crc_o == '0) && !done_o);

   assert_direct_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SHIFT && form == FORM_DIRECT && valid_i && last_i && !start_i) |=> done_o);

   assert_pad_no_early_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PAD && pad_cnt != PAD_LAST && !start_i) |=> !done_o);

   assert_pad_final_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PAD && pad_cnt == PAD_LAST && !start_i) |=> done_o);

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !start_i) |=> $stable(crc_o));

   assert_direct_no_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PAD) |-> (form == FORM_AUGMENT));
endmodule

bind crc_dual_serial crc_dual_serial_chk #(.W(W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .valid_i (valid_i),
   .last_i  (last_i),
   .crc_o   (crc_o),
   .done_o  (done_o),
   .st      (ctl_state),
   .form    (form),
   .pad_cnt (pad_cnt)
);

// File: tb/crc_dual_serial_tb.sv
module crc_dual_serial_tb;
   localparam int           W    = 5;
   localparam logic [W-1:0] POLY = 5'b00111;
   localparam int           NV   = 8;
   // entry: [22] mode, [21] idle gaps, [20:16] length, [15:0] message
   localparam logic [22:0] VEC [NV] = '{
      {1'b0, 1'b0, 5'd8,  16'h0093},
      {1'b1, 1'b0, 5'd8,  16'h0093},
      {1'b0, 1'b1, 5'd16, 16'hBEEF},
      {1'b1, 1'b1, 5'd16, 16'hBEEF},
      {1'b0, 1'b0, 5'd1,  16'h0001},
      {1'b1, 1'b0, 5'd1,  16'h0001},
      {1'b0, 1'b1, 5'd3,  16'h0005},
      {1'b1, 1'b1, 5'd12, 16'h0A5C}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic start_i = 0, mode_i = 0, valid_i = 0, bit_i = 0, last_i = 0;
   logic [W-1:0] crc_o;
   logic done_o;
   int n_chk = 0, n_fail = 0, cycles = 0;

   always #4 clk = ~clk;

   crc_dual_serial #(.W(W), .POLY(POLY)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .valid_i(valid_i), .bit_i(bit_i), .last_i(last_i),
      .crc_o(crc_o), .done_o(done_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // polynomial long division of M(x)*x^W by G(x)
   function automatic logic [W-1:0] ref_rem(input logic [15:0] msg, input int len);
      logic [31:0] a;
      logic [31:0] g;
      a = 32'(msg) << W;
      g = {27'd0, 1'b1, POLY};
      for (int i = len + W - 1; i >= W; i--)
         if (a[i]) a = a ^ (g << (i - W));
      return a[W-1:0];
   endfunction

   task automatic send(input logic [15:0] msg, input int len, input bit mode,
                       input bit gaps, input bit noise,
                       output logic [W-1:0] res, output int lat);
      @(negedge clk);
      start_i = 1; mode_i = mode;
      @(negedge clk);
      start_i = 0;
      for (int i = len - 1; i >= 0; i--) begin
         if (gaps) begin
            valid_i = 0; bit_i = ~msg[i]; last_i = 1;
            @(negedge clk);
         end
         valid_i = 1; bit_i = msg[i]; last_i = (i == 0);
         @(negedge clk);
      end
      lat = 1;
      if (noise) begin valid_i = 1; bit_i = 1; last_i = 1; end
      else       begin valid_i = 0; last_i = 0; end
      while (!done_o && lat < 40) begin
         @(negedge clk);
         lat++;
      end
      res = crc_o;
      valid_i = 0; last_i = 0; bit_i = 0;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
         end
      end
   end

   initial begin
      logic [W-1:0] res;
      logic [W-1:0] held;
      int lat;
      repeat (3) @(negedge clk);
      // R12: reset state
      chk(crc_o == '0, "R12 crc after reset", crc_o, 0);
      chk(!done_o, "R12 done after reset", done_o, 0);
      rst_n = 1;

      // R5/R6/R7/R8 via the vector table
      for (int v = 0; v < NV; v++) begin
         send(VEC[v][15:0], int'(VEC[v][20:16]), VEC[v][22], VEC[v][21], 1'b0, res, lat);
         chk(res == ref_rem(VEC[v][15:0], int'(VEC[v][20:16])), "R5 remainder",
             res, ref_rem(VEC[v][15:0], int'(VEC[v][20:16])));
         if (VEC[v][22]) chk(lat == W + 1, "R7 augmented latency", lat, W + 1);
         else            chk(lat == 1, "R6 direct latency", lat, 1);
         @(negedge clk);
         chk(!done_o, "R8 done width", done_o, 0);
      end

      // R1/R3: known 8-bit case, direct form
      send(16'h0093, 8, 1'b0, 1'b0, 1'b0, res, lat);
      chk(res == 5'b01010, "R1 R3 direct 10010011", res, 5'b01010);
      // R1/R4/R10: augmented with input held busy during padding
      send(16'h0093, 8, 1'b1, 1'b0, 1'b1, res, lat);
      chk(res == 5'b01010, "R1 R4 R10 augmented 10010011", res, 5'b01010);
      chk(lat == W + 1, "R10 latency with noise", lat, W + 1);

      // R9: result held while idle input toggles
      held = crc_o;
      for (int k = 0; k < 6; k++) begin
         valid_i = 1; bit_i = k[0]; last_i = k[1];
         @(negedge clk);
      end
      valid_i = 0; last_i = 0;
      chk(crc_o == held, "R9 hold after done", crc_o, held);
      chk(!done_o, "R9 no extra done", done_o, 0);

      // R2: start clears, same-cycle bit discarded
      @(negedge clk);
      start_i = 1; mode_i = 0; valid_i = 1; bit_i = 1;
      @(negedge clk);
      start_i = 0; valid_i = 0;
      chk(crc_o == '0, "R2 clear on start", crc_o, 0);

      // R11: abort an augmented message mid-way, restart in direct form
      @(negedge clk);
      start_i = 1; mode_i = 1;
      @(negedge clk);
      start_i = 0;
      for (int k = 0; k < 4; k++) begin
         valid_i = 1; bit_i = 1; last_i = 0;
         @(negedge clk);
      end
      valid_i = 0;
      send(16'h00C3, 8, 1'b0, 1'b0, 1'b0, res, lat);
      chk(res == ref_rem(16'h00C3, 8), "R11 restart result", res, ref_rem(16'h00C3, 8));
      chk(lat == 1, "R11 restart uses new form", lat, 1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule